// File: doc/BRIEF.md
# Self-Recovering Modified One-Hot Ring Sequencer

This block steps through eight phases in a fixed cycle and keeps its state in only seven flip-flops. Phase 0 is the all-zero vector. Each later phase holds a single 1, and that 1 moves up one bit position every time the advance enable is high on a clock edge. A 1 that leaves the top bit is dropped, so the ring returns to all-zero. A NOR of the state bits then feeds a fresh 1 into the bottom bit on the next advance.

The same two mechanisms also bring the ring back after a transient upset, with no decoded reset. If upsets leave every bit clear, the NOR path restarts the ring. If they leave surplus 1s, those 1s shift off the top until at most one remains.

Eight fully decoded phase strobes drive downstream logic, and a multi-hot flag reports an illegal pattern. An upset-mask input XORs bits into the state register at the clock edge. It exists so that the recovery behaviour can be exercised.

Top module: `mohot_ring_seq`

## Requirements
- R1: While rst_n is low the state is 0000000, phase strobe 0 is high, every other strobe is low and multi_hot_o is low.
- R2: An edge with adv_en high, starting from state 0000000, gives state 0000001 (value 1).
- R3: An edge with adv_en high, starting from a non-zero state, gives the state shifted left one bit with a 0 in bit 0; the old bit 6 is discarded.
- R4: An edge with adv_en low leaves the state unchanged.
- R5: From reset, eight advances pass through 0, 1, 2, 4, 8, 16, 32, 64 in that order and return to 0.
- R6: phase_o[0] is high only when the state is all zero. phase_o[k] for k from 1 to 7 is high only when the state equals 1 shifted left by k-1. Any multi-hot state drives every strobe low.
- R7: multi_hot_o is high exactly when two or more state bits are 1.
- R8: On every edge, upset_mask is XORed into the value the state would otherwise take (after the advance or hold selection).
- R9: From any state pattern, with upset_mask zero, at most 6 advances bring the state back to a legal value (all zero or a single 1). Once legal, it never leaves the legal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to phase 0 |
| adv_en | input | 1 | Advance the ring by one phase on this edge |
| upset_mask | input | 7 | Bits XORed into the state register at the edge (upset emulation) |
| state_o | output | 7 | Current state vector |
| phase_o | output | 8 | Fully decoded phase strobes |
| multi_hot_o | output | 1 | High when more than one state bit is set |

## Verification
The bench goes after the wrap from the top bit back to all-zero and the re-injection that follows it. A design that injected on any advance, rather than only from zero, would grow a second 1 and run multi-hot. It also loads every one of the 128 possible state patterns through the upset mask and steps each one until it recovers. A ring that rotated its top bit back into bit 0 would keep a bad pattern circulating for ever and fail the recovery check. Strobe decoding is compared for every pattern, so a partial decode that lit a strobe on a multi-hot state is reported.

// File: rtl/mohot_pkg.sv
package mohot_pkg;

  // Summary flags derived from the state vector, shared by the decode,
  // next-state and checker logic.
  typedef struct packed {
    logic all_zero;   // phase 0, also the re-injection condition
    logic multi_hot;  // two or more bits set: illegal
    logic legal;      // all zero or exactly one bit set
  } ring_stat_t;

endpackage

// File: rtl/mohot_decode.sv
module mohot_decode
  import mohot_pkg::*;
#(
  parameter int SW = 7,
  localparam int NP = SW + 1
) (
  input  logic [SW-1:0] state,
  output logic [NP-1:0] phase,
  output ring_stat_t    stat
);

  // Count set bits with a loop so that it is clear which arithmetic is used.
  function automatic int unsigned ones(input logic [SW-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < SW; i++) n += int'(v[i]);
    return n;
  endfunction

  // Pattern that a given non-zero phase must match exactly.
  function automatic logic [SW-1:0] phase_pat(input int k);
    logic [SW-1:0] p;
    p = '0;
    p[k-1] = 1'b1;
    return p;
  endfunction

  int unsigned pop;
  always_comb pop = ones(state);

  assign stat.all_zero  = (pop == 0);
  assign stat.multi_hot = (pop > 1);
  assign stat.legal     = (pop <= 1);

  assign phase[0] = stat.all_zero;

  for (genvar k = 1; k < NP; k++) begin : g_phase
    assign phase[k] = (state == phase_pat(k));
  end

endmodule

// File: rtl/mohot_next.sv
module mohot_next #(
  parameter int SW = 7
) (
  input  logic [SW-1:0] state,
  input  logic          all_zero,
  input  logic          adv,
  output logic [SW-1:0] nxt,
  output logic          inject_fire
);

  // One ring step: move every bit up, drop the top one, and feed bit 0 from
  // the NOR of the state (the all-zero flag).
  function automatic logic [SW-1:0] ring_step(input logic [SW-1:0] s,
                                              input logic          z);
    return {s[SW-2:0], z};
  endfunction

  assign inject_fire = adv & all_zero;
  assign nxt         = adv ? ring_step(state, all_zero) : state;

endmodule

// File: rtl/mohot_reg.sv
module mohot_reg #(
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] d,
  input  logic [SW-1:0] flip,
  output logic [SW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d ^ flip;
  end

endmodule

// File: rtl/mohot_ring_seq.sv
module mohot_ring_seq
  import mohot_pkg::*;
#(
  parameter int NUM_PHASES = 8,
  localparam int SW = NUM_PHASES - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv_en,
  input  logic [SW-1:0]         upset_mask,
  output logic [SW-1:0]         state_o,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  multi_hot_o
);

  logic [SW-1:0] ring_q;
  logic [SW-1:0] ring_d;
  ring_stat_t    ring_stat;
  logic          inject_fire;   // named event for the checker
  logic          ring_legal;    // named event for the checker

  mohot_decode #(.SW(SW)) u_decode (
    .state (ring_q),
    .phase (phase_o),
    .stat  (ring_stat)
  );

  mohot_next #(.SW(SW)) u_next (
    .state       (ring_q),
    .all_zero    (ring_stat.all_zero),
    .adv         (adv_en),
    .nxt         (ring_d),
    .inject_fire (inject_fire)
  );

  mohot_reg #(.SW(SW)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ring_d),
    .flip  (upset_mask),
    .q     (ring_q)
  );

  assign ring_legal  = ring_stat.legal;
  assign state_o     = ring_q;
  assign multi_hot_o = ring_stat.multi_hot;

endmodule

// File: rtl/mohot_ring_chk.sv
module mohot_ring_chk #(
  parameter int SW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_en,
  input logic [SW-1:0] upset_mask,
  input logic [SW-1:0] state_o,
  input logic [SW:0]   phase_o,
  input logic          multi_hot_o,
  input logic          inject_fire,
  input logic          ring_legal
);

  // Advances taken while the state is illegal; cleared once it is legal
  // again or when an upset disturbs it.
  logic [7:0] bad_adv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 bad_adv <= '0;
    else if (upset_mask != '0)  bad_adv <= '0;
    else if (ring_legal)        bad_adv <= '0;
    else if (adv_en && bad_adv != 8'hFF) bad_adv <= bad_adv + 8'd1;
  end

  AST_INJECT_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inject_fire && upset_mask == '0) |=> state_o == SW'(1)); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && state_o != '0 && upset_mask == '0)
      |=> state_o == $past({state_o[SW-2:0], 1'b0})); // R3

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_en && upset_mask == '0) |=> $stable(state_o)); // R4

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_o)); // R6

  AST_STROBE_DARK_ON_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hot_o |-> phase_o == '0); // R6

  AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hot_o == ($countones(state_o) > 1)); // R7

  AST_UPSET_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_en) |=> state_o == $past(state_o ^ upset_mask)); // R8

  AST_RECOVERY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bad_adv <= 8'(SW - 1)); // R9

  AST_LEGAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_legal && upset_mask == '0) |=> ring_legal); // R9

endmodule

bind mohot_ring_seq mohot_ring_chk #(.SW(SW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adv_en      (adv_en),
  .upset_mask  (upset_mask),
  .state_o     (state_o),
  .phase_o     (phase_o),
  .multi_hot_o (multi_hot_o),
  .inject_fire (inject_fire),
  .ring_legal  (ring_legal)
);

// File: tb/tb_mohot_ring_seq.sv
`timescale 1ns/1ps
module tb_mohot_ring_seq;

  localparam int NP = 8;
  localparam int SW = NP - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          adv_en = 1'b0;
  logic [SW-1:0] upset_mask = '0;
  logic [SW-1:0] state_o;
  logic [NP-1:0] phase_o;
  logic          multi_hot_o;

  int checks = 0;
  int failures = 0;
  logic [SW-1:0] model = '0;

  always #5 clk = ~clk;

  mohot_ring_seq #(.NUM_PHASES(NP)) dut (
    .clk (clk), .rst_n (rst_n), .adv_en (adv_en), .upset_mask (upset_mask),
    .state_o (state_o), .phase_o (phase_o), .multi_hot_o (multi_hot_o)
  );

  // Reference step, written as arithmetic: doubling modulo 2^SW, plus one
  // when the value is zero.
  function automatic logic [SW-1:0] ref_step(input logic [SW-1:0] s,
                                             input logic a,
                                             input logic [SW-1:0] m);
    int unsigned v;
    v = s;
    if (a) v = (v == 0) ? 1 : ((v * 2) % (1 << SW));
    return SW'(v) ^ m;
  endfunction

  function automatic int popc(input logic [SW-1:0] s);
    int n = 0;
    for (int i = 0; i < SW; i++) if (s[i]) n++;
    return n;
  endfunction

  function automatic logic [NP-1:0] ref_phase(input logic [SW-1:0] s);
    logic [NP-1:0] p = '0;
    if (s == 0) p[0] = 1'b1;
    else if (popc(s) == 1)
      for (int i = 0; i < SW; i++) if (s[i]) p[i+1] = 1'b1;
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    chk({req, " state"}, 32'(state_o), 32'(model));
    chk("R6 phase", 32'(phase_o), 32'(ref_phase(model)));
    chk("R7 multi_hot", 32'(multi_hot_o), 32'(popc(model) > 1));
  endtask

  task automatic step(input logic a, input logic [SW-1:0] m);
    @(negedge clk);
    adv_en = a;
    upset_mask = m;
    model = ref_step(model, a, m);
    @(posedge clk);
    #1;
    @(negedge clk);
    adv_en = 1'b0;
    upset_mask = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    adv_en = 1'b0;
    upset_mask = '0;
    #2;
    model = '0;
    chk("R1 reset state", 32'(state_o), 0);
    chk("R1 reset phase", 32'(phase_o), 1);
    chk("R1 reset multi_hot", 32'(multi_hot_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  logic done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2 R3 R5: two full laps, checking the expected value arithmetically.
    for (int lap = 0; lap < 2; lap++) begin
      for (int i = 0; i < NP; i++) begin
        step(1'b1, '0);
        chk("R5 sequence", 32'(state_o), (i == NP - 1) ? 0 : (1 << i));
        check_outputs(i == 0 ? "R2" : "R3");
      end
      chk("R5 lap returns to zero", 32'(state_o), 0);
    end

    // R4: hold at several phases.
    for (int i = 0; i < 4; i++) begin
      step(1'b1, '0);
      for (int h = 0; h < 3; h++) begin
        step(1'b0, '0);
        check_outputs("R4 hold");
      end
    end

    // R8 R9: every state pattern, loaded by upset, stepped to recovery.
    for (int p = 0; p < (1 << SW); p++) begin
      do_reset();
      step(1'b0, SW'(p));
      chk("R8 upset load", 32'(state_o), p);
      check_outputs("R8");
      for (int k = 0; k < SW - 1; k++) begin
        step(1'b1, '0);
        check_outputs("R3 recovery step");
      end
      chk("R9 legal after 6 advances", 32'(multi_hot_o), 0);
      for (int k = 0; k < NP; k++) begin
        step(1'b1, '0);
        chk("R9 stays legal", 32'(multi_hot_o), 0);
      end
    end

    // R8: upset combined with an advance on the same edge.
    do_reset();
    step(1'b1, '0);
    step(1'b1, 7'b0000101);
    chk("R8 upset with advance", 32'(state_o), 32'(7'b0000111));
    check_outputs("R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule